// File: doc/BRIEF.md
# Pulse-Width Single-Wire Slave Responder

This block is the slave end of an open-drain single-wire link that encodes each bit in the length of a low pulse. A pulse about one time unit long is a sync mark, about three units is a 0 and about six units is a 1. The block samples the line, measures every low pulse and classifies it. It waits for a preamble of sync marks and then assembles a frame header. The header holds a direction flag, a 3-bit node address, a 4-bit register index and a parity bit.

When the header is addressed to this node, the block takes one of two paths. On a write, it collects a data byte and its parity bit from the master, then reports the outcome. On a read, it answers in slots that the master opens with short low pulses. The block stretches each of these pulses to the 0 or 1 length. In both cases the frame closes with an acknowledge bit, which the slave always drives. The register side is a plain register-file port: an index, write data, a one-cycle write strobe and read data that the host returns for the index being presented.

Top module: `pwm_wire_slave`

## Requirements
- R1: A header is accepted only after at least three consecutive sync pulses. A header preceded by fewer than three is ignored: no write strobe, and no drive in the ack slot.
- R2: With U = UNIT_CYC clock cycles, a low pulse is classified by its length L in cycles, in this order of checks:
  - L < U/2 is invalid.
  - L < 2U is sync.
  - L < 4.5U is 0.
  - Otherwise it is 1.
  An invalid pulse breaks a preamble.
- R3: Header bits arrive most significant first: direction, node address bits 2..0, register index bits 3..0, then P1. The block responds only when direction = 0.
- R4: Register index bit 3 = 1 selects a write. Eight data bits follow, MSB first, then P2. If every check passes, `reg_we_o` pulses for exactly one cycle with `reg_addr_o` equal to the index and `reg_wdata_o` equal to the byte.
- R5: Register index bit 3 = 0 selects a read. The block returns `reg_rdata_i`, sampled at the P1 pulse, MSB first over eight slots, then P2.
- R6: To send a bit, the slave takes the line low within one unit of the master's falling edge. It holds the line for 3U (bit 0) or 6U (bit 1) and then releases it. The slave never pulls the line outside read-data and ack slots.
- R7: The ack is 0 on success. The ack is 1, and no write happens, in any of these cases:
  - P1 is wrong.
  - P2 is wrong.
  - A write data slot holds a sync or invalid pulse.
  P1 and P2 are 1 exactly when the covered bits hold an odd number of ones.
- R8: A frame whose node address differs from `node_addr_i` is ignored with the line left alone. The next full preamble starts a new frame.
- R9: A low pulse reaching MAX_UNITS·U cycles aborts any frame in progress. The pulse produces no bit, and the block waits for a new preamble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_i | input | 1 | Sampled level of the shared line (1 = released) |
| bus_pull_o | output | 1 | 1 pulls the shared line low |
| node_addr_i | input | 3 | Node address this slave answers to |
| reg_addr_o | output | 4 | Register index from the current header |
| reg_wdata_o | output | 8 | Data byte for a write |
| reg_we_o | output | 1 | One-cycle write strobe |
| reg_rdata_i | input | 8 | Read data for `reg_addr_o` |

## Verification
The bench builds the block with UNIT_CYC = 8 and MAX_UNITS = 10, and it sets the node address to 5. With these values a full frame costs roughly 1,500 cycles, so every pulse class fits comfortably inside the run. Each classification edge can be driven to the exact cycle: 3 versus 4, 15 versus 16 and 35 versus 36 cycles, with the 80-cycle abort just above a 75-cycle 1. The short unit also keeps the three-to-four-cycle sampling latency of the slave's stretched bits inside one unit.

// File: rtl/pwm_wire_pkg.sv
package pwm_wire_pkg;

    typedef enum logic [1:0] {
        PK_BAD,
        PK_SYNC,
        PK_ZERO,
        PK_ONE
    } pulse_kind_e;

    typedef enum logic [2:0] {
        FS_HUNT,
        FS_HDR,
        FS_WDATA,
        FS_RDATA,
        FS_ACK
    } frame_st_e;

endpackage

// File: rtl/pwm_pulse_meter.sv
module pwm_pulse_meter
    import pwm_wire_pkg::*;
#(
    parameter int UNIT_CYC  = 16,
    parameter int MAX_UNITS = 10
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        line_i,
    output logic        fall_o,
    output logic        done_o,
    output logic        tout_o,
    output pulse_kind_e kind_o
);
    localparam int MAX_CYC  = UNIT_CYC * MAX_UNITS;
    localparam int CW       = $clog2(MAX_CYC + 1);
    localparam int MIN_SYNC = (UNIT_CYC / 2 > 0) ? UNIT_CYC / 2 : 1;
    localparam int MIN_ZERO = 2 * UNIT_CYC;
    localparam int MIN_ONE  = (9 * UNIT_CYC) / 2;

    typedef struct packed {
        logic          s1;
        logic          s2;
        logic          prev;
        logic [CW-1:0] len;
        logic          fall;
        logic          done;
        logic          tout;
        pulse_kind_e   kind;
    } meter_t;

    localparam meter_t M_RST = '{s1: 1'b1, s2: 1'b1, prev: 1'b1, len: '0,
                                 fall: 1'b0, done: 1'b0, tout: 1'b0, kind: PK_BAD};

    meter_t m_d, m_q;

    always_comb begin
        m_d      = m_q;
        m_d.s1   = line_i;
        m_d.s2   = m_q.s1;
        m_d.prev = m_q.s2;
        m_d.fall = 1'b0;
        m_d.done = 1'b0;
        m_d.tout = 1'b0;
        if (!m_q.s2) begin
            if (m_q.prev) begin
                m_d.len  = CW'(1);
                m_d.fall = 1'b1;
            end else if (m_q.len < CW'(MAX_CYC)) begin
                m_d.len = m_q.len + 1'b1;
                if (m_q.len == CW'(MAX_CYC - 1)) m_d.tout = 1'b1;
            end
        end else if (!m_q.prev && (m_q.len < CW'(MAX_CYC))) begin
            m_d.done = 1'b1;
            if (m_q.len < CW'(MIN_SYNC))      m_d.kind = PK_BAD;
            else if (m_q.len < CW'(MIN_ZERO)) m_d.kind = PK_SYNC;
            else if (m_q.len < CW'(MIN_ONE))  m_d.kind = PK_ZERO;
            else                              m_d.kind = PK_ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) m_q <= M_RST;
        else        m_q <= m_d;
    end

    assign fall_o = m_q.fall;
    assign done_o = m_q.done;
    assign tout_o = m_q.tout;
    assign kind_o = m_q.kind;

    // R9
    tout_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tout_o |=> (!tout_o && !done_o));

endmodule

// File: rtl/pwm_bit_driver.sv
module pwm_bit_driver #(
    parameter int UNIT_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic bit_i,
    output logic pull_o
);
    localparam int ZERO_CYC = 3 * UNIT_CYC;
    localparam int ONE_CYC  = 6 * UNIT_CYC;
    localparam int DW       = $clog2(ONE_CYC + 1);

    typedef struct packed {
        logic [DW-1:0] left;
        logic          pull;
    } drv_t;

    drv_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (start_i && !r_q.pull) begin
            r_d.left = bit_i ? DW'(ONE_CYC) : DW'(ZERO_CYC);
            r_d.pull = 1'b1;
        end else if (r_q.left > DW'(1)) begin
            r_d.left = r_q.left - 1'b1;
            r_d.pull = 1'b1;
        end else begin
            r_d.left = '0;
            r_d.pull = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign pull_o = r_q.pull;

    logic [DW:0] run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      run_q <= '0;
        else if (pull_o) run_q <= run_q + 1'b1;
        else             run_q <= '0;
    end

    // R6
    pull_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= (DW + 1)'(ONE_CYC));

endmodule

// File: rtl/pwm_wire_slave.sv
module pwm_wire_slave
    import pwm_wire_pkg::*;
#(
    parameter int UNIT_CYC  = 16,
    parameter int MAX_UNITS = 10,
    parameter int ADDR_W    = 3,
    parameter int REG_W     = 4,
    parameter int DATA_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_i,
    output logic              bus_pull_o,
    input  logic [ADDR_W-1:0] node_addr_i,
    output logic [REG_W-1:0]  reg_addr_o,
    output logic [DATA_W-1:0] reg_wdata_o,
    output logic              reg_we_o,
    input  logic [DATA_W-1:0] reg_rdata_i
);
    localparam int HDR_W  = 1 + ADDR_W + REG_W;
    localparam int CNT_MX = (HDR_W > DATA_W) ? HDR_W : DATA_W;
    localparam int CNT_W  = $clog2(CNT_MX + 1);

    typedef struct packed {
        frame_st_e         st;
        logic [1:0]        syncs;
        logic [CNT_W-1:0]  cnt;
        logic [HDR_W-1:0]  hdr;
        logic [DATA_W-1:0] data;
        logic              par;
        logic              err;
        logic              we;
    } fsm_t;

    localparam fsm_t F_RST = '{st: FS_HUNT, syncs: '0, cnt: '0, hdr: '0,
                               data: '0, par: 1'b0, err: 1'b0, we: 1'b0};

    logic        p_fall, p_done, p_tout;
    pulse_kind_e p_kind;
    logic        tx_start, tx_bit;

    pwm_pulse_meter #(
        .UNIT_CYC (UNIT_CYC),
        .MAX_UNITS(MAX_UNITS)
    ) u_meter (
        .clk   (clk),
        .rst_n (rst_n),
        .line_i(bus_i),
        .fall_o(p_fall),
        .done_o(p_done),
        .tout_o(p_tout),
        .kind_o(p_kind)
    );

    pwm_bit_driver #(
        .UNIT_CYC(UNIT_CYC)
    ) u_drv (
        .clk    (clk),
        .rst_n  (rst_n),
        .start_i(tx_start),
        .bit_i  (tx_bit),
        .pull_o (bus_pull_o)
    );

    fsm_t f_d, f_q;
    logic is_data, bit_v, p2_bad;

    always_comb begin
        f_d      = f_q;
        f_d.we   = 1'b0;
        is_data  = (p_kind == PK_ZERO) || (p_kind == PK_ONE);
        bit_v    = (p_kind == PK_ONE);
        p2_bad   = 1'b0;
        tx_bit   = (f_q.st == FS_ACK) ? f_q.err
                 : ((f_q.cnt == CNT_W'(DATA_W)) ? f_q.par : f_q.data[DATA_W-1]);
        tx_start = p_fall && ((f_q.st == FS_RDATA) || (f_q.st == FS_ACK));

        if (p_tout) begin
            f_d.st    = FS_HUNT;
            f_d.syncs = '0;
        end else if (p_done) begin
            unique case (f_q.st)
                FS_HUNT: begin
                    if (p_kind == PK_SYNC) begin
                        if (f_q.syncs != 2'd3) f_d.syncs = f_q.syncs + 1'b1;
                    end else if (is_data && (f_q.syncs == 2'd3)) begin
                        f_d.hdr   = {f_q.hdr[HDR_W-2:0], bit_v};
                        f_d.cnt   = CNT_W'(1);
                        f_d.st    = FS_HDR;
                        f_d.syncs = '0;
                    end else begin
                        f_d.syncs = '0;
                    end
                end
                FS_HDR: begin
                    if (!is_data) begin
                        f_d.st    = FS_HUNT;
                        f_d.syncs = (p_kind == PK_SYNC) ? 2'd1 : 2'd0;
                    end else if (f_q.cnt != CNT_W'(HDR_W)) begin
                        f_d.hdr = {f_q.hdr[HDR_W-2:0], bit_v};
                        f_d.cnt = f_q.cnt + 1'b1;
                    end else if (!f_q.hdr[HDR_W-1] &&
                                 (f_q.hdr[HDR_W-2 -: ADDR_W] == node_addr_i)) begin
                        f_d.err  = ((^f_q.hdr) != bit_v);
                        f_d.cnt  = '0;
                        f_d.par  = ^reg_rdata_i;
                        f_d.data = f_q.hdr[REG_W-1] ? '0 : reg_rdata_i;
                        f_d.st   = f_q.hdr[REG_W-1] ? FS_WDATA : FS_RDATA;
                    end else begin
                        f_d.st    = FS_HUNT;
                        f_d.syncs = '0;
                    end
                end
                FS_WDATA: begin
                    if (f_q.cnt != CNT_W'(DATA_W)) begin
                        f_d.data = {f_q.data[DATA_W-2:0], bit_v};
                        f_d.err  = f_q.err | !is_data;
                        f_d.cnt  = f_q.cnt + 1'b1;
                    end else begin
                        p2_bad  = !is_data || ((^f_q.data) != bit_v);
                        f_d.err = f_q.err | p2_bad;
                        f_d.we  = !(f_q.err | p2_bad);
                        f_d.st  = FS_ACK;
                    end
                end
                FS_RDATA: begin
                    f_d.data = {f_q.data[DATA_W-2:0], 1'b0};
                    f_d.cnt  = f_q.cnt + 1'b1;
                    if (f_q.cnt == CNT_W'(DATA_W)) f_d.st = FS_ACK;
                end
                FS_ACK: begin
                    f_d.st    = FS_HUNT;
                    f_d.syncs = '0;
                end
                default: f_d = F_RST;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= F_RST;
        else        f_q <= f_d;
    end

    assign reg_addr_o  = f_q.hdr[REG_W-1:0];
    assign reg_wdata_o = f_q.data;
    assign reg_we_o    = f_q.we;

    // R4
    we_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we_o |=> !reg_we_o);

    // R7
    we_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we_o |-> (f_q.st == FS_ACK && !f_q.err && reg_addr_o[REG_W-1]));

    // R6
    pull_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_pull_o |-> (f_q.st == FS_RDATA || f_q.st == FS_ACK));

    // R1
    pause_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (f_q.st == FS_HDR && $past(f_q.st) == FS_HUNT) |-> ($past(f_q.syncs) == 2'd3));

endmodule

// File: tb/pwm_wire_slave_bench.sv
`timescale 1ns/1ps
module pwm_wire_slave_bench;
    localparam int U    = 8;
    localparam int MAXU = 10;
    localparam int GAP  = 3 * U;
    localparam logic [2:0] NODE = 3'd5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_pull = 1'b0;
    logic       s_pull;
    logic       line;
    logic [3:0] reg_addr;
    logic [7:0] reg_wdata, reg_rdata;
    logic       reg_we;
    logic [7:0] mem [16];

    int vectors = 0;
    int miscompares = 0;
    int sl = U, zl = 3 * U, ol = 6 * U;
    bit finished = 1'b0;

    typedef struct { logic [3:0] a; logic [7:0] d; } wr_t;
    wr_t exp_q[$];

    always #10 clk = ~clk;

    assign line      = ~(m_pull | s_pull);
    assign reg_rdata = mem[reg_addr];

    pwm_wire_slave #(.UNIT_CYC(U), .MAX_UNITS(MAXU)) u_pwm_wire_slave (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_i      (line),
        .bus_pull_o (s_pull),
        .node_addr_i(NODE),
        .reg_addr_o (reg_addr),
        .reg_wdata_o(reg_wdata),
        .reg_we_o   (reg_we),
        .reg_rdata_i(reg_rdata)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Scoreboard monitor: R4 write strobes against the expectation queue
    always @(negedge clk) begin
        if (rst_n && reg_we) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R4/R7 unexpected write", {reg_addr, reg_wdata}, -1);
            end else begin
                wr_t e;
                e = exp_q.pop_front();
                check(reg_addr == e.a && reg_wdata == e.d, "R4 write strobe",
                      {reg_addr, reg_wdata}, {e.a, e.d});
            end
        end
    end

    task automatic pulse(input int cyc);
        m_pull = 1'b1;
        repeat (cyc) @(negedge clk);
        m_pull = 1'b0;
        repeat (GAP) @(negedge clk);
    endtask

    task automatic sendb(input bit b);
        pulse(b ? ol : zl);
    endtask

    // 0/1 = slave bit, 2 = line not stretched by the slave
    task automatic slot(output int code);
        int len;
        len = 0;
        m_pull = 1'b1;
        repeat (U) begin @(negedge clk); len++; end
        m_pull = 1'b0;
        while (line == 1'b0 && len < 20 * U) begin @(negedge clk); len++; end
        repeat (GAP) @(negedge clk);
        code = (len < 2 * U) ? 2 : ((len < (9 * U) / 2) ? 0 : 1);
    endtask

    task automatic header(input int syncs, input bit dir, input logic [2:0] a,
                          input logic [3:0] r, input bit p1bad);
        logic [7:0] h;
        h = {dir, a, r};
        repeat (syncs) pulse(sl);
        for (int i = 7; i >= 0; i--) sendb(h[i]);
        sendb((^h) ^ p1bad);
    endtask

    task automatic write_frame(input int syncs, input logic [2:0] a, input logic [3:0] r,
                               input logic [7:0] d, input bit p1bad, input bit p2bad,
                               input int badslot, input int exp_ack, input bit exp_wr,
                               input string tag);
        int c;
        if (exp_wr) begin
            wr_t e;
            e.a = r; e.d = d;
            exp_q.push_back(e);
            mem[r] = d;
        end
        header(syncs, 1'b0, a, r, p1bad);
        for (int i = 7; i >= 0; i--) begin
            if (7 - i == badslot) pulse(U);
            else                  sendb(d[i]);
        end
        sendb((^d) ^ p2bad);
        slot(c);
        check(c == exp_ack, tag, c, exp_ack);
        check(exp_q.size() == 0, "R4 pending write", exp_q.size(), 0);
    endtask

    task automatic read_frame(input int syncs, input bit dir, input logic [2:0] a,
                              input logic [3:0] r, input bit p1bad, input bit driven,
                              input int exp_ack, input string tag);
        int c, cp, ca;
        bit undriven, okbits;
        logic [7:0] got;
        undriven = 1'b1; okbits = 1'b1; got = '0;
        header(syncs, dir, a, r, p1bad);
        for (int i = 7; i >= 0; i--) begin
            slot(c);
            if (c != 2) undriven = 1'b0;
            if (c == 2) okbits = 1'b0;
            got[i] = (c == 1);
        end
        slot(cp);
        slot(ca);
        if (driven) begin
            check(okbits && got == mem[r], "R5/R6 read data", got, mem[r]);
            check(cp == int'(^mem[r]), "R5 read P2", cp, int'(^mem[r]));
            check(ca == exp_ack, tag, ca, exp_ack);
        end else begin
            check(undriven && cp == 2 && ca == 2, tag, ca, 2);
        end
    endtask

    initial begin
        for (int i = 0; i < 16; i++) mem[i] = 8'(i * 37 + 11);
        mem[3] = 8'h96;
        mem[1] = 8'h01;
        repeat (5) @(negedge clk);
        // R6: reset state
        check(s_pull == 1'b0, "R6 reset pull", s_pull, 0);
        check(reg_we == 1'b0, "R4 reset strobe", reg_we, 0);
        rst_n = 1'b1;
        repeat (4 * U) @(negedge clk);

        write_frame(3, NODE, 4'hA, 8'hC5, 0, 0, -1, 0, 1, "R4/R7 good write ack");
        read_frame(3, 1'b0, NODE, 4'h3, 0, 1, 0, "R5/R7 good read ack");
        read_frame(5, 1'b0, NODE, 4'h1, 0, 1, 0, "R1 long preamble read ack");
        write_frame(2, NODE, 4'hB, 8'h33, 0, 0, -1, 2, 0, "R1 short preamble ignored");
        write_frame(3, NODE ^ 3'd1, 4'hC, 8'h44, 0, 0, -1, 2, 0, "R8 other node write ignored");
        read_frame(3, 1'b0, NODE ^ 3'd4, 4'h3, 0, 0, 2, "R8 other node read undriven");
        read_frame(3, 1'b1, NODE, 4'h3, 0, 0, 2, "R3 direction 1 ignored");
        write_frame(3, NODE, 4'h9, 8'h5A, 1, 0, -1, 1, 0, "R7 P1 error ack");
        write_frame(3, NODE, 4'h9, 8'h5A, 0, 1, -1, 1, 0, "R7 P2 error ack");
        write_frame(3, NODE, 4'h9, 8'h5A, 0, 0, 2, 1, 0, "R7 sync in data ack");
        read_frame(3, 1'b0, NODE, 4'h6, 1, 1, 1, "R7 read P1 error ack");
        write_frame(3, NODE, 4'h8, 8'h81, 0, 0, -1, 0, 1, "R3 recovery after errors");

        // R2: classification at the exact thresholds
        sl = 15; zl = 16; ol = 36;
        write_frame(3, NODE, 4'hD, 8'hA6, 0, 0, -1, 0, 1, "R2 lower thresholds");
        sl = 4; zl = 35; ol = 75;
        write_frame(3, NODE, 4'hE, 8'h6B, 0, 0, -1, 0, 1, "R2 upper thresholds");
        sl = U; zl = 3 * U; ol = 6 * U;

        // R2: a too-short pulse breaks the preamble
        pulse(U); pulse(U); pulse(3);
        write_frame(2, NODE, 4'hB, 8'h77, 0, 0, -1, 2, 0, "R2 glitch breaks preamble");

        // R9: a long low pulse where the last address bit (1) would sit aborts the frame
        begin
            int c;
            repeat (3) pulse(U);
            sendb(1'b0); sendb(1'b1); sendb(1'b0);
            pulse(12 * U);
            sendb(1'b1); sendb(1'b0); sendb(1'b0); sendb(1'b1);
            sendb(1'b0);
            for (int i = 7; i >= 0; i--) sendb(i[0]);
            sendb(1'b0);
            slot(c);
            check(c == 2, "R9 timeout aborts frame", c, 2);
            check(exp_q.size() == 0, "R9 no write after timeout", exp_q.size(), 0);
        end
        write_frame(3, NODE, 4'hF, 8'h3C, 0, 0, -1, 0, 1, "R9 recovery after timeout");

        repeat (10) @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            vectors++;
            miscompares++;
            $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule